// File: doc/BRIEF.md
# Triggered SAR ADC Readout Controller

This block runs one serial successive-approximation converter over a three-wire link. The convert-start line also acts as the chip select. A single-cycle trigger pulse starts each sample. The controller raises the convert line and keeps it high for a programmed number of core cycles so that the conversion can finish. It then drops the line and produces a serial clock from an internal prescaler. It shifts in an 18-bit result, most significant bit first, on one data input.

At high serial clock rates the round trip through pads and the converter gets long. To cover it, the moment each data bit is latched can be pushed back by zero to three core cycles after the serial clock rises. The finished sample is zero-extended into a 32-bit word and offered as one AXI4-Stream beat. Triggers that arrive while the controller is busy are refused, and so are results that cannot be delivered. Either case sets a sticky overrun flag.

The sample rate is set entirely by the external trigger. The trigger period must be long enough to cover the conversion hold, the readout, the acquisition time the converter needs, and a one-cycle return to idle.

Top module: `sar_readout_ctrl`

## Requirements
- R1: A trigger sampled high while the controller is idle raises `adc_cnv` in the next cycle. The line then stays high for exactly `conv_cycles` core cycles and falls afterwards.
- R2: A `conv_cycles` value of zero is treated as a hold of one core cycle.
- R3: `adc_sclk` stays low while idle and while `adc_cnv` is high. During readout it makes exactly 18 pulses. Each high phase and each low phase lasts `sclk_div + 1` core cycles. The first rising edge comes `sclk_div + 1` cycles after `adc_cnv` falls.
- R4: Data bits are taken most significant bit first. The bit for the i-th rising edge of `adc_sclk` is the value of `adc_sdi` sampled at the core clock edge 1 + `sample_dly` cycles after the edge where `adc_sclk` rose. `sample_dly` ranges over 0..3.
- R5: The result sits in `m_axis_tdata[17:0]` and bits 31..18 are zero.
- R6: The result is offered one cycle after the later of two events: the last falling edge of `adc_sclk`, and the last data capture. `m_axis_tvalid` and `m_axis_tdata` then hold steady until a cycle in which `m_axis_tready` is high.
- R7: A trigger that arrives while a conversion, readout or hand-off is in progress does not disturb the transfer in flight. Such a trigger sets `overrun`, and the flag stays set until reset.
- R8: A result that completes while the previous beat is still unaccepted is discarded. The pending beat is kept unchanged and `overrun` is set.
- R9: A synchronous active-low reset returns the controller to idle with `adc_cnv`, `adc_sclk`, `m_axis_tvalid` and `overrun` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig | input | 1 | Single-cycle sample start pulse |
| sclk_div | input | 8 | Prescaler; each serial clock phase lasts sclk_div+1 cycles |
| conv_cycles | input | 12 | Convert-line hold time in core cycles |
| sample_dly | input | 2 | Extra core cycles before each data bit is latched |
| adc_sdi | input | 1 | Serial data from the converter |
| adc_cnv | output | 1 | Convert start / chip select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| m_axis_tdata | output | 32 | Zero-extended sample |
| m_axis_tvalid | output | 1 | Stream beat valid |
| m_axis_tready | input | 1 | Stream beat accepted |
| overrun | output | 1 | Sticky flag for a lost trigger or a lost result |

## Verification
Two pairs of functions can fall in the same clock edge. The first pair is the publication of a finished result and the arrival of the next trigger. The bench places a trigger exactly on the publication edge and expects it to be refused with `overrun` set. It also places a trigger one edge later and expects that one to start a clean transfer. The second pair is publication and a downstream handshake. With `m_axis_tready` toggled at random, the bench checks that a result landing on an accepting edge replaces the old beat, while one landing on a stalled edge is dropped. A behavioural model predicts every output on every cycle and decides both cases.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CONV  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_TAIL  = 2'd3
   } sar_state_t;
endpackage

// File: rtl/sar_sclk_div.sv
// Serial clock prescaler: each phase lasts div+1 core cycles while run is high.
module sar_sclk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             sclk,
   output logic             rise_q,
   output logic             fall_now
);
   logic [DIV_W-1:0] ph_q;
   logic             term;

   assign term     = run && (ph_q == div);
   assign fall_now = term && sclk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= '0;
         sclk   <= 1'b0;
         rise_q <= 1'b0;
      end else begin
         rise_q <= term && !sclk;
         if (!run) begin
            ph_q <= '0;
            sclk <= 1'b0;
         end else if (term) begin
            ph_q <= '0;
            sclk <= ~sclk;
         end else begin
            ph_q <= ph_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sar_sdi_delay.sv
// Delays the capture strobe by a selectable number of core cycles.
module sar_sdi_delay #(
   parameter int MAX_DLY = 3,
   localparam int SEL_W  = $clog2(MAX_DLY + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic [SEL_W-1:0] sel,
   output logic             tap
);
   logic [MAX_DLY-1:0] pipe_q;

   generate
      if (MAX_DLY == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= strobe;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= {pipe_q[MAX_DLY-2:0], strobe};
         end
      end
   endgenerate

   always_comb begin
      tap = pipe_q[MAX_DLY-1];
      if (sel == '0) tap = strobe;
      for (int j = 1; j <= MAX_DLY; j++) begin
         if (sel == SEL_W'(j)) tap = pipe_q[j-1];
      end
   end
endmodule

// File: rtl/sar_axis_hold.sv
// Single-entry stream output; a load while a beat is stalled is dropped.
module sar_axis_hold #(
   parameter int SAMPLE_W = 18,
   parameter int WORD_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic                tready,
   output logic                tvalid,
   output logic [WORD_W-1:0]   tdata,
   output logic                drop
);
   logic stalled;

   assign stalled = tvalid && !tready;
   assign drop    = load && stalled;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tvalid <= 1'b0;
         tdata  <= '0;
      end else if (load && !stalled) begin
         tvalid <= 1'b1;
         tdata  <= WORD_W'(sample);
      end else if (tvalid && tready) begin
         tvalid <= 1'b0;
      end
   end
endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl #(
   parameter int SAMPLE_W = 18,
   parameter int WORD_W   = 32,
   parameter int DIV_W    = 8,
   parameter int CONV_W   = 12,
   parameter int MAX_DLY  = 3,
   localparam int SEL_W   = $clog2(MAX_DLY + 1),
   localparam int BIT_W   = $clog2(SAMPLE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [DIV_W-1:0]  sclk_div,
   input  logic [CONV_W-1:0] conv_cycles,
   input  logic [SEL_W-1:0]  sample_dly,
   input  logic              adc_sdi,
   output logic              adc_cnv,
   output logic              adc_sclk,
   output logic [WORD_W-1:0] m_axis_tdata,
   output logic              m_axis_tvalid,
   input  logic              m_axis_tready,
   output logic              overrun
);
   import sar_pkg::*;

   generate
      if (WORD_W <= SAMPLE_W) begin : g_bad_word
         $error("WORD_W must exceed SAMPLE_W");
      end
      if (SAMPLE_W < 2) begin : g_bad_sample
         $error("SAMPLE_W must be at least 2");
      end
      if (MAX_DLY < 1) begin : g_bad_dly
         $error("MAX_DLY must be at least 1");
      end
   endgenerate

   sar_state_t          state;
   logic [CONV_W-1:0]   cnt_q;
   logic [CONV_W-1:0]   conv_last;
   logic [BIT_W-1:0]    nfall_q;
   logic [BIT_W-1:0]    nbits_q;
   logic [SAMPLE_W-1:0] shreg_q;
   logic                run;
   logic                rise_q;
   logic                fall_now;
   logic                tap;
   logic                publish;
   logic                drop;
   logic                busy_trig;

   assign conv_last = (conv_cycles == '0) ? '0 : conv_cycles - 1'b1;
   assign run       = (state == ST_SHIFT);
   assign publish   = (state == ST_TAIL) && (nbits_q == BIT_W'(SAMPLE_W));
   assign busy_trig = trig && (state != ST_IDLE);

   sar_sclk_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .div      (sclk_div),
      .sclk     (adc_sclk),
      .rise_q   (rise_q),
      .fall_now (fall_now)
   );

   sar_sdi_delay #(.MAX_DLY(MAX_DLY)) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (rise_q),
      .sel    (sample_dly),
      .tap    (tap)
   );

   sar_axis_hold #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (publish),
      .sample (shreg_q),
      .tready (m_axis_tready),
      .tvalid (m_axis_tvalid),
      .tdata  (m_axis_tdata),
      .drop   (drop)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         adc_cnv <= 1'b0;
         cnt_q   <= '0;
         nfall_q <= '0;
         nbits_q <= '0;
         shreg_q <= '0;
         overrun <= 1'b0;
      end else begin
         overrun <= overrun | busy_trig | drop;
         if (tap) begin
            shreg_q <= {shreg_q[SAMPLE_W-2:0], adc_sdi};
            nbits_q <= nbits_q + 1'b1;
         end
         unique case (state)
            ST_IDLE: begin
               if (trig) begin
                  state   <= ST_CONV;
                  adc_cnv <= 1'b1;
                  cnt_q   <= '0;
                  nfall_q <= '0;
                  nbits_q <= '0;
               end
            end
            ST_CONV: begin
               if (cnt_q == conv_last) begin
                  state   <= ST_SHIFT;
                  adc_cnv <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_SHIFT: begin
               if (fall_now) begin
                  nfall_q <= nfall_q + 1'b1;
                  if (nfall_q == BIT_W'(SAMPLE_W - 1)) state <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (publish) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sar_readout_ctrl_chk.sv
module sar_readout_ctrl_chk #(
   parameter int SAMPLE_W = 18,
   parameter int WORD_W   = 32,
   localparam int BIT_W   = $clog2(SAMPLE_W + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                trig,
   input logic                adc_cnv,
   input logic                adc_sclk,
   input logic [WORD_W-1:0]   m_axis_tdata,
   input logic                m_axis_tvalid,
   input logic                m_axis_tready,
   input logic                overrun,
   input sar_pkg::sar_state_t state,
   input logic [BIT_W-1:0]    nbits_q
);
   import sar_pkg::*;

   p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && trig) |=> (adc_cnv && state == ST_CONV));

   p_sclk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      adc_cnv |-> !adc_sclk);

   p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      m_axis_tvalid |-> (m_axis_tdata[WORD_W-1:SAMPLE_W] == '0));

   p_hold_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (m_axis_tvalid && !m_axis_tready) |=> (m_axis_tvalid && $stable(m_axis_tdata)));

   p_busy_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && state != ST_IDLE) |=> overrun);

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TAIL && nbits_q == BIT_W'(SAMPLE_W) && m_axis_tvalid && !m_axis_tready)
      |=> overrun);

   p_reset_r9: assert property (@(posedge clk)
      !rst_n |=> (!adc_cnv && !adc_sclk && !m_axis_tvalid && !overrun));
endmodule

bind sar_readout_ctrl sar_readout_ctrl_chk #(
   .SAMPLE_W (SAMPLE_W),
   .WORD_W   (WORD_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .trig          (trig),
   .adc_cnv       (adc_cnv),
   .adc_sclk      (adc_sclk),
   .m_axis_tdata  (m_axis_tdata),
   .m_axis_tvalid (m_axis_tvalid),
   .m_axis_tready (m_axis_tready),
   .overrun       (overrun),
   .state         (state),
   .nbits_q       (nbits_q)
);

// File: tb/sar_readout_ctrl_test.sv
`timescale 1ns/1ps
module sar_readout_ctrl_test;
   localparam int NB = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig = 1'b0;
   logic [7:0]  sclk_div = '0;
   logic [11:0] conv_cycles = 12'd5;
   logic [1:0]  sample_dly = '0;
   logic        adc_sdi = 1'b0;
   logic        adc_cnv, adc_sclk, m_axis_tvalid, overrun;
   logic        m_axis_tready = 1'b1;
   logic [31:0] m_axis_tdata;

   always #2 clk = ~clk;

   sar_readout_ctrl uut (
      .clk(clk), .rst_n(rst_n), .trig(trig), .sclk_div(sclk_div),
      .conv_cycles(conv_cycles), .sample_dly(sample_dly), .adc_sdi(adc_sdi),
      .adc_cnv(adc_cnv), .adc_sclk(adc_sclk), .m_axis_tdata(m_axis_tdata),
      .m_axis_tvalid(m_axis_tvalid), .m_axis_tready(m_axis_tready), .overrun(overrun)
   );

   int checks = 0, fails = 0, x = 0;
   bit done = 0, mvalid = 0, last_rst = 0, rnd_rdy = 0;
   logic rstn_drv = 1'b0, rdy_v = 1'b1;
   logic hist [int];
   // reference model state
   bit act = 0;
   int t0, s, cC, H, D, P;
   logic e_cnv = 0, e_sclk = 0, e_tv = 0, e_ov = 0;
   logic [31:0] e_td = '0;

   task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
      checks++;
      if (a !== e) begin
         fails++;
         $display("FAIL %s edge=%0d actual=%h expected=%h", tag, x, a, e);
      end
   endtask

   task automatic model_edge(input logic t);
      bit nonidle, hs;
      int u;
      logic [31:0] w;
      if (!rstn_drv) begin
         act = 0; e_cnv = 0; e_sclk = 0; e_tv = 0; e_ov = 0;
         mvalid = 1; last_rst = 1;
         return;
      end
      last_rst = 0;
      nonidle = act && (x - 1 >= t0) && (x - 1 < P);
      hs = e_tv && rdy_v;
      if (act && x == P) begin
         w = '0;
         for (int i = 1; i <= NB; i++) w[NB-i] = hist[s + (2*i-1)*H + 1 + D];
         if (e_tv && !rdy_v) e_ov = 1;
         else begin e_td = w; e_tv = 1; end
      end else if (hs) e_tv = 0;
      if (t) begin
         if (nonidle) e_ov = 1;
         else begin
            act = 1; t0 = x;
            cC = (conv_cycles == 0) ? 1 : int'(conv_cycles);
            H = int'(sclk_div) + 1; D = int'(sample_dly);
            s = t0 + cC;
            P = ((s + 2*NB*H) > (s + (2*NB-1)*H + 1 + D) ? (s + 2*NB*H) : (s + (2*NB-1)*H + 1 + D)) + 1;
         end
      end
      e_cnv = act && (x >= t0) && (x <= t0 + cC - 1);
      u = x - s;
      e_sclk = act && (u >= 0) && (u < 2*NB*H) && (((u / H) % 2) == 1);
   endtask

   task automatic step(input logic t);
      @(negedge clk);
      if (mvalid) begin
         chk(last_rst ? "R9 cnv" : "R1 R2 R7 cnv", 32'(adc_cnv), 32'(e_cnv));
         chk(last_rst ? "R9 sclk" : "R3 sclk", 32'(adc_sclk), 32'(e_sclk));
         chk(last_rst ? "R9 tvalid" : "R6 R8 tvalid", 32'(m_axis_tvalid), 32'(e_tv));
         chk(last_rst ? "R9 overrun" : "R7 R8 overrun", 32'(overrun), 32'(e_ov));
         if (e_tv) chk("R4 R5 R8 tdata", m_axis_tdata, e_td);
      end
      trig = t;
      rst_n = rstn_drv;
      if (rnd_rdy) rdy_v = 1'($urandom % 2);
      m_axis_tready = rdy_v;
      adc_sdi = 1'($urandom % 2);
      x++;
      hist[x] = adc_sdi;
      model_edge(t);
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) step(1'b0);
   endtask

   task automatic do_reset();
      rstn_drv = 1'b0; cyc(2); rstn_drv = 1'b1;
   endtask

   initial begin
      rstn_drv = 1'b0; cyc(3); rstn_drv = 1'b1; cyc(2);
      // R1 R3 R4 R5 R6: fastest clock, no capture delay
      step(1); cyc(55);
      // R2: zero hold time, slow clock, longest capture delay
      sclk_div = 8'd2; conv_cycles = 12'd0; sample_dly = 2'd3;
      step(1); cyc(125);
      // R4 R6: capture delay outlasts the last falling edge
      sclk_div = 8'd0; conv_cycles = 12'd2; sample_dly = 2'd3;
      step(1); cyc(50);
      // back-to-back triggers, each on the first idle edge
      sclk_div = 8'd1; conv_cycles = 12'd3; sample_dly = 2'd1;
      for (int k = 0; k < 3; k++) begin step(1); cyc(76); end
      cyc(10);
      // R8: stalled stream, second result dropped
      sclk_div = 8'd0; conv_cycles = 12'd5; sample_dly = 2'd0; rdy_v = 1'b0;
      step(1); cyc(50); step(1); cyc(50);
      rdy_v = 1'b1; cyc(5);
      do_reset(); cyc(2);
      // R7: triggers during hold, readout, and on the publication edge
      step(1); cyc(3); step(1); cyc(20); step(1); cyc(30);
      do_reset(); cyc(2);
      sclk_div = 8'd1; conv_cycles = 12'd3; sample_dly = 2'd1;
      step(1); cyc(75); step(1); cyc(90);
      // random downstream readiness
      do_reset(); cyc(2); rnd_rdy = 1;
      for (int k = 0; k < 4; k++) begin step(1); cyc(50); end
      rnd_rdy = 0; rdy_v = 1'b1; cyc(5);
      // R9: reset in the middle of a conversion
      step(1); cyc(2); do_reset(); cyc(5);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired at edge %0d", x);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule